// File: doc/BRIEF.md
# Flash Chip-Select Timing Sequencer

This block frames each serial flash transaction in time. A start request, taken while the block is enabled and idle, runs a fixed order of phases. An optional gap comes first. Then the select is asserted and a setup wait runs. A burst of divided serial clock periods follows, then a hold wait with the select still asserted. Last, the select is released and a recovery wait runs before the block reports idle again. Every wait is a programmable count of reference clock cycles. Some waits also carry a fixed extra length tied to the serial clock period.

The select output drives one of four flash devices. It can be a one-hot active-low pattern, or the raw select field passed through for an external decoder. The serial clock idles at a programmable polarity. Two single-cycle strobes, launch and capture, mark the reference cycles in which the serial clock shows a new edge, so a separate data shifter can move bits in step.

All configuration inputs are copied into shadow registers only while the block is disabled and idle. A running transaction therefore cannot be disturbed by configuration changes.

Top module: `fsel_timing_seq`

## Requirements
- R1: The serial clock half period is cfg_div+1 reference cycles. A transaction of N periods shows 2N sclk edges, with (2N-1)*(cfg_div+1) cycles from the first edge to the last.
- R2: Outside the clocking phase, sclk rests at the captured cfg_cpol level.
- R3: With cfg_decode=0, the low two bits of cfg_sel give an index k. While selected, cs_n is all ones except bit k, which is 0 (index 1 gives 4'b1101, index 3 gives 4'b0111).
- R4: With cfg_decode=1, cs_n carries cfg_sel unchanged while selected. When nothing is selected, cs_n is 4'b1111 in both modes.
- R5: The first sclk edge comes cfg_t_setup+cfg_div+2 cycles after cs_n changes to its selected value.
- R6: cs_n returns to all ones cfg_t_hold+2*(cfg_div+1)+3 cycles after the last sclk edge.
- R7: busy falls cfg_t_desel+2*(cfg_div+1)+1 cycles after cs_n returns to all ones.
- R8: If the select pattern differs from the previous transaction's pattern, cs_n changes cfg_t_gap+2 cycles after the clock edge that samples start. Otherwise, including the first transaction after reset, it changes 1 cycle after that edge.
- R9: With cfg_cpha=0, capture pulses on leading edges and launch pulses on trailing edges. With cfg_cpha=1 the roles swap. Each strobe is high exactly in the cycles where sclk shows a new level, and each fires N times.
- R10: busy rises on the cycle after a start is accepted. A start is ignored while busy is high or enable is low.
- R11: Configuration inputs are captured only while enable is low and the block is idle. Changes made while enabled have no effect.
- R12: After reset, cs_n is all ones, and sclk, busy, launch and capture are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low opens configuration capture |
| start | input | 1 | Transaction request, sampled when idle and enabled |
| xfer_cycles | input | 8 | Serial clock periods for this transaction, sampled with start |
| cfg_div | input | 4 | Clock divider; sclk period is 2*(cfg_div+1) cycles |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase; selects which edge launches |
| cfg_decode | input | 1 | 1: pass the select field through; 0: one-hot decode |
| cfg_sel | input | 4 | Select field (index in low bits, or raw code) |
| cfg_t_desel | input | 8 | Recovery wait after deselect |
| cfg_t_setup | input | 8 | Wait from select to clocking |
| cfg_t_hold | input | 8 | Wait from last edge to deselect |
| cfg_t_gap | input | 8 | Extra wait before selecting a different device |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Chip-select lines |
| launch | output | 1 | Strobe: sclk shows a launch edge this cycle |
| capture | output | 1 | Strobe: sclk shows a capture edge this cycle |
| busy | output | 1 | Transaction in progress, up to the end of recovery |

## Verification
The hardest state to reach from the ports is the device-change gap. It needs two transactions in a row whose select patterns differ, and the pattern can change only through a disable, reconfigure and enable sequence between them. The bench chains its scenarios so that each reconfiguration both changes the device and exercises a new clock mode. One run then reaches the gap after one-hot, pass-through and low-index selects. A further test changes the configuration inputs while the block stays enabled, and checks that the next transaction keeps the old pattern, divider and no-gap timing.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_SETUP, ST_CLK, ST_HOLD, ST_DESEL
  } phase_e;
endpackage

// File: rtl/fsel_sel_encode.sv
module fsel_sel_encode #(
  parameter int NCS = 4
) (
  input  logic           decode,
  input  logic [NCS-1:0] sel,
  output logic [NCS-1:0] pat
);
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1;

  logic [NCS-1:0] onehot_n;

  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign onehot_n[i] = (sel[SEL_W-1:0] != SEL_W'(i));
  end

  assign pat = decode ? sel : onehot_n;
endmodule

// File: rtl/fsel_phase_timer.sv
module fsel_phase_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign done = (cnt_q == '0);

  // Phase lengths in R5-R7 rely on a strict one-per-cycle countdown
  p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/fsel_clkgen.sv
module fsel_clkgen #(
  parameter int DIV_W  = 4,
  parameter int XFER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [XFER_W-1:0] cycles,
  output logic              sclk,
  output logic              launch,
  output logic              capture,
  output logic              last
);
  localparam int EW = XFER_W + 1;

  logic [DIV_W-1:0] half_q;
  logic [EW-1:0]    edges_q;
  logic             sclk_q, launch_q, capture_q;
  logic             tick, lead;

  assign tick = run && (half_q == '0);
  assign last = tick && (edges_q == EW'(1));
  assign lead = ~edges_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q    <= '0;
      edges_q   <= '0;
      sclk_q    <= 1'b0;
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
    end else begin
      launch_q  <= tick && (lead == cpha);
      capture_q <= tick && (lead != cpha);
      if (go) begin
        half_q  <= div;
        edges_q <= {cycles, 1'b0};
        sclk_q  <= cpol;
      end else if (run) begin
        if (tick) begin
          sclk_q  <= ~sclk_q;
          half_q  <= div;
          edges_q <= edges_q - EW'(1);
        end else begin
          half_q  <= half_q - DIV_W'(1);
        end
      end else begin
        sclk_q <= cpol;
      end
    end
  end

  assign sclk    = sclk_q;
  assign launch  = launch_q;
  assign capture = capture_q;

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_q && capture_q));
  p_strobe_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_q || capture_q) |-> (sclk_q != $past(sclk_q)));
endmodule

// File: rtl/fsel_timing_seq.sv
module fsel_timing_seq #(
  parameter int NCS    = 4,
  parameter int DIV_W  = 4,
  parameter int DLY_W  = 8,
  parameter int XFER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic [XFER_W-1:0] xfer_cycles,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_decode,
  input  logic [NCS-1:0]    cfg_sel,
  input  logic [DLY_W-1:0]  cfg_t_desel,
  input  logic [DLY_W-1:0]  cfg_t_setup,
  input  logic [DLY_W-1:0]  cfg_t_hold,
  input  logic [DLY_W-1:0]  cfg_t_gap,
  output logic              sclk,
  output logic [NCS-1:0]    cs_n,
  output logic              launch,
  output logic              capture,
  output logic              busy
);
  import fsel_pkg::*;

  localparam int TMR_W = DLY_W + DIV_W + 2;

  // shadow configuration
  logic [DIV_W-1:0] div_q;
  logic             cpol_q, cpha_q, dec_q;
  logic [NCS-1:0]   sel_q;
  logic [DLY_W-1:0] tdes_q, tset_q, thold_q, tgap_q;

  phase_e            st_q, st_d;
  logic [XFER_W-1:0] xfer_q;
  logic [NCS-1:0]    pattern, last_pat_q;
  logic              last_vld_q;
  logic              cfg_open, accept, need_gap;
  logic              tmr_load, tmr_done, clk_go, clk_run, clk_last;
  logic [TMR_W-1:0]  tmr_val, hold_len, desel_len;

  assign cfg_open = !enable && (st_q == ST_IDLE);
  assign accept   = enable && start && (st_q == ST_IDLE);
  assign need_gap = last_vld_q && (last_pat_q != pattern);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0; dec_q <= 1'b0;
      sel_q  <= '0; tdes_q <= '0; tset_q <= '0; thold_q <= '0; tgap_q <= '0;
    end else if (cfg_open) begin
      div_q  <= cfg_div;     cpol_q <= cfg_cpol;    cpha_q  <= cfg_cpha;
      dec_q  <= cfg_decode;  sel_q  <= cfg_sel;     tdes_q  <= cfg_t_desel;
      tset_q <= cfg_t_setup; thold_q <= cfg_t_hold; tgap_q  <= cfg_t_gap;
    end
  end

  fsel_sel_encode #(.NCS(NCS)) u_enc (
    .decode (dec_q),
    .sel    (sel_q),
    .pat    (pattern)
  );

  // fixed extras folded into the loaded count (count+1 cycles per phase)
  assign hold_len  = TMR_W'(thold_q) + (TMR_W'(div_q) << 1) + TMR_W'(4);
  assign desel_len = TMR_W'(tdes_q)  + (TMR_W'(div_q) << 1) + TMR_W'(2);

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    clk_go   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (need_gap) begin st_d = ST_GAP;   tmr_val = TMR_W'(tgap_q); end
        else          begin st_d = ST_SETUP; tmr_val = TMR_W'(tset_q); end
      end
      ST_GAP: if (tmr_done) begin
        st_d = ST_SETUP; tmr_load = 1'b1; tmr_val = TMR_W'(tset_q);
      end
      ST_SETUP: if (tmr_done) begin
        if (xfer_q != '0) begin
          st_d = ST_CLK; clk_go = 1'b1;
        end else begin
          st_d = ST_HOLD; tmr_load = 1'b1; tmr_val = hold_len;
        end
      end
      ST_CLK: if (clk_last) begin
        st_d = ST_HOLD; tmr_load = 1'b1; tmr_val = hold_len;
      end
      ST_HOLD: if (tmr_done) begin
        st_d = ST_DESEL; tmr_load = 1'b1; tmr_val = desel_len;
      end
      ST_DESEL: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      xfer_q     <= '0;
      last_pat_q <= '1;
      last_vld_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        xfer_q     <= xfer_cycles;
        last_pat_q <= pattern;
        last_vld_q <= 1'b1;
      end
    end
  end

  fsel_phase_timer #(.W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .val   (tmr_val),
    .done  (tmr_done)
  );

  assign clk_run = (st_q == ST_CLK);

  fsel_clkgen #(.DIV_W(DIV_W), .XFER_W(XFER_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (clk_go),
    .run     (clk_run),
    .div     (div_q),
    .cpol    (cpol_q),
    .cpha    (cpha_q),
    .cycles  (xfer_q),
    .sclk    (sclk),
    .launch  (launch),
    .capture (capture),
    .last    (clk_last)
  );

  assign cs_n = (st_q == ST_SETUP || st_q == ST_CLK || st_q == ST_HOLD) ? pattern : '1;
  assign busy = (st_q != ST_IDLE);

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE && $stable(cpol_q)) |-> (sclk == cpol_q));
  p_onehot_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_q |-> $onehot0(~cs_n));
  p_no_select_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n == '1));
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(div_q) && $stable(sel_q) && $stable(dec_q) && $stable(cpol_q)));
endmodule

// File: tb/fsel_timing_seq_bench.sv
module fsel_timing_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, start = 1'b0;
  logic [7:0] xfer_cycles = '0;
  logic [3:0] cfg_div = '0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_decode = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [7:0] cfg_t_desel = '0, cfg_t_setup = '0, cfg_t_hold = '0, cfg_t_gap = '0;
  logic       sclk, launch, capture, busy;
  logic [3:0] cs_n;

  always #10 clk = ~clk;

  fsel_timing_seq u_fsel_timing_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .xfer_cycles(xfer_cycles), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_decode(cfg_decode), .cfg_sel(cfg_sel),
    .cfg_t_desel(cfg_t_desel), .cfg_t_setup(cfg_t_setup),
    .cfg_t_hold(cfg_t_hold), .cfg_t_gap(cfg_t_gap),
    .sclk(sclk), .cs_n(cs_n), .launch(launch), .capture(capture), .busy(busy)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  int m_on, m_first, m_last, m_off, m_idle, m_tog, m_lau, m_cap, m_mis, m_fp, m_busy1;
  logic [3:0] m_pat;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(input int dv, input bit pol, input bit pha, input bit dec,
                           input int sel, input int tdes, input int tset,
                           input int thold, input int tgap);
    @(negedge clk);
    enable = 1'b0;
    cfg_div = 4'(dv); cfg_cpol = pol; cfg_cpha = pha; cfg_decode = dec;
    cfg_sel = 4'(sel); cfg_t_desel = 8'(tdes); cfg_t_setup = 8'(tset);
    cfg_t_hold = 8'(thold); cfg_t_gap = 8'(tgap);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  // one transaction; index n = samples after the edge that took start
  task automatic run_txn(input int xf);
    logic prev_sclk;
    @(negedge clk);
    xfer_cycles = 8'(xf); start = 1'b1; prev_sclk = sclk;
    @(negedge clk);
    start = 1'b0;
    m_on = -1; m_first = -1; m_last = -1; m_off = -1; m_idle = -1;
    m_tog = 0; m_lau = 0; m_cap = 0; m_mis = 0; m_fp = 0; m_pat = 4'hF;
    m_busy1 = busy;
    for (int n = 1; n < 3000; n++) begin
      if (m_on < 0 && cs_n != 4'hF) begin m_on = n; m_pat = cs_n; end
      if (m_on >= 0 && m_off < 0 && cs_n == 4'hF) m_off = n;
      if (sclk != prev_sclk) begin
        m_tog++;
        if (m_first < 0) m_first = n;
        m_last = n;
      end
      if ((launch || capture) != (sclk != prev_sclk)) m_mis++;
      if (launch) m_lau++;
      if (capture) m_cap++;
      if (m_fp == 0) m_fp = launch ? 1 : (capture ? 2 : 0);
      prev_sclk = sclk;
      if (!busy) begin m_idle = n; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_timing(input int dv, input int tset, input int thold,
                              input int tdes, input int xf, input int gap);
    int p;
    p = 2 * (dv + 1);
    chk("R10 busy after accept", m_busy1, 1);
    chk("R8 select delay", m_on, (gap >= 0) ? gap + 2 : 1);
    chk("R5 select to first edge", m_first - m_on, tset + dv + 2);
    chk("R1 edge count", m_tog, 2 * xf);
    chk("R1 first to last edge", m_last - m_first, (2 * xf - 1) * (dv + 1));
    chk("R6 last edge to deselect", m_off - m_last, thold + p + 3);
    chk("R7 deselect to idle", m_idle - m_off, tdes + p + 1);
    chk("R9 launch count", m_lau, xf);
    chk("R9 capture count", m_cap, xf);
    chk("R9 strobes only on edges", m_mis, 0);
  endtask

  task automatic t_reset;
    chk("R12 cs_n", int'(cs_n), 15);
    chk("R12 busy", int'(busy), 0);
    chk("R12 sclk", int'(sclk), 0);
    chk("R12 launch", int'(launch), 0);
    chk("R12 capture", int'(capture), 0);
  endtask

  task automatic t_mode0;
    configure(1, 0, 0, 0, 1, 3, 2, 1, 5);
    chk("R2 idle level low", int'(sclk), 0);
    run_txn(3);
    check_timing(1, 2, 1, 3, 3, -1);
    chk("R3 one-hot index 1", int'(m_pat), 4'b1101);
    chk("R9 cpha0 first strobe is capture", m_fp, 2);
  endtask

  task automatic t_same_device;
    run_txn(2);
    check_timing(1, 2, 1, 3, 2, -1);
  endtask

  task automatic t_mode3_gap;
    configure(0, 1, 1, 0, 3, 0, 0, 0, 4);
    @(negedge clk);
    chk("R2 idle level high", int'(sclk), 1);
    run_txn(2);
    check_timing(0, 0, 0, 0, 2, 4);
    chk("R3 one-hot index 3", int'(m_pat), 4'b0111);
    chk("R9 cpha1 first strobe is launch", m_fp, 1);
    chk("R2 level after transaction", int'(sclk), 1);
  endtask

  task automatic t_decode;
    configure(2, 0, 1, 1, 4'b1010, 2, 1, 2, 3);
    run_txn(1);
    check_timing(2, 1, 2, 2, 1, 3);
    chk("R4 pass-through field", int'(m_pat), 4'b1010);
  endtask

  task automatic t_slow_div;
    configure(15, 0, 0, 0, 0, 0, 0, 0, 0);
    run_txn(2);
    check_timing(15, 0, 0, 0, 2, 0);
    chk("R3 one-hot index 0", int'(m_pat), 4'b1110);
  endtask

  task automatic t_cfg_locked;
    @(negedge clk);
    cfg_sel = 4'd2; cfg_div = 4'd3; cfg_decode = 1'b1; cfg_t_setup = 8'd9;
    repeat (3) @(negedge clk);
    run_txn(1);
    check_timing(15, 0, 0, 0, 1, -1);
    chk("R11 pattern unchanged while enabled", int'(m_pat), 4'b1110);
  endtask

  task automatic t_start_ignored;
    int extra;
    configure(0, 0, 0, 0, 0, 1, 1, 1, 2);
    @(negedge clk);
    xfer_cycles = 8'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    extra = 0;
    for (int i = 0; i < 10; i++) begin
      if (busy || cs_n != 4'hF) extra++;
      @(negedge clk);
    end
    chk("R10 start while busy ignored", extra, 0);
    enable = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 start while disabled ignored", int'(busy), 0);
    chk("R10 no select while disabled", int'(cs_n), 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_same_device();
    t_mode3_gap();
    t_decode();
    t_slow_div();
    t_cfg_locked();
    t_start_ignored();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule